// File: doc/BRIEF.md
# Power-Good Supervisor with Hiccup Restart

This block watches a set of buck converter rails through comparator flags and decides when the supply as a whole may be reported good. Each channel supplies three digital flags. One says the rail is below 85% of nominal. One says it is above 90%. The third comes from a hysteretic comparator and says the rail is over-voltage: it sets at 109% and clears at 107%. A channel-select mask states which rails take part. A sequencing-done input reports that the start-up sequencer has finished. A tick input pulses once per switching cycle. Every timer counts these ticks, never raw clocks, so all time intervals scale inversely with the switching frequency.

The power-good output is active high. It rises only after three things are true: sequencing is done, every selected rail has been judged good through its deglitch filter, and a reset timer has then run out. It falls when any selected rail is judged low through the same filter. A rail that was good and then stays low for the hiccup on-time starts a restart. The block raises a global restart request and forces every high-side switch off for the hiccup off-time. It then releases all rails so they can start up again. An over-voltage on a selected rail inhibits only that rail's high-side switch and leaves power-good alone.

At the default 500 kHz switching clock, the defaults give these tick counts: deglitch 5500 (11 ms), hiccup on-time 6000 (12 ms) and off-time 7500 (15 ms). The reset timer default is 10^6 ticks, which is 1 s at 1 MHz.

Top module: `pgood_supervisor`

## Requirements
- R1: After reset, `pgood` is 0, `restartReq` is 0 and every bit of `hsOff` is 0.
- R2: Bit i of each per-channel vector is channel i. A channel becomes judged good when `aboveHi[i]` has been held through DEGLITCH_CYC consecutive ticks. The reset timer then counts ticks only while `seqDone` is high and every selected channel is judged good. `pgood` rises one clock after the timer reaches RESET_CYC. With one tick per clock, this is DEGLITCH_CYC+RESET_CYC+1 clocks after good flags and `seqDone` are applied. If `seqDone` falls, `pgood` falls on the next clock and the timer restarts from zero.
- R3: When `belowLo[i]` of a selected, judged-good channel has been held through DEGLITCH_CYC consecutive ticks, that channel is judged low and `pgood` falls one clock later. A shorter run of `belowLo` has no effect.
- R4: While a channel has neither `belowLo` nor `aboveHi` set (between 85% and 90%), its judged state does not change.
- R5: A selected channel that goes from judged good to judged low marks a fault. If the fault lasts HICCUP_ON_CYC further ticks, `restartReq` rises, all `hsOff` bits are 1 and `pgood` is 0.
- R6: `restartReq` stays high for exactly HICCUP_OFF_CYC ticks and then falls, and `hsOff` returns to the over-voltage mask. After a restart, every channel starts out not judged good, so `pgood` needs the full deglitch and reset time again.
- R7: `hsOff[i]` is 1 on the clock after `ovFlag[i]` is seen high on a selected channel, and 0 on the clock after it clears. An over-voltage does not change `pgood`.
- R8: Channels whose `chanSel` bit is 0 are ignored by the good check, the fault check and the over-voltage path. With no channel selected, `pgood` rises RESET_CYC+1 clocks after `seqDone` (one tick per clock).
- R9: Every interval counts `cycTick` pulses, not clocks. With one tick every third clock, power-good takes about three times as many clocks to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycTick | input | 1 | One pulse per switching cycle; timer time base |
| chanSel | input | NCH | Channel participation mask |
| seqDone | input | 1 | Start-up sequencing has completed |
| belowLo | input | NCH | Rail below 85% of nominal |
| aboveHi | input | NCH | Rail above 90% of nominal |
| ovFlag | input | NCH | Rail over-voltage (hysteretic 109%/107%) |
| pgood | output | 1 | Power-good, active high |
| restartReq | output | 1 | Hiccup off-time: all converters disabled |
| hsOff | output | NCH | Per-channel high-side switch inhibit |

## Verification
The assertions assume that the comparator flags are self-consistent: `belowLo[i]` and `aboveHi[i]` are never high together. They also assume HICCUP_ON_CYC is at least 2, so that `pgood` has already dropped before a restart can begin. The stimulus drives each channel as a rail would: good, low or in the band, never both flags at once. Inputs change only on the falling clock edge, and the tick is either held high or pulsed once every few clocks.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
  typedef enum logic {PH_RUN = 1'b0, PH_OFF = 1'b1} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic filtClr;   // clear all channel filters (off-time)
    logic rstRun;    // reset timer may count; clears when low
    logic hicCount;  // hiccup counter may count
    logic hicClr;    // hiccup counter clear (priority)
  } pgs_strobe_t;
endpackage

// File: rtl/pgs_datapath.sv
`timescale 1ns/1ps
module pgs_datapath
  import pgs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DEGLITCH_CYC = 5500,
  parameter int RESET_CYC = 1000000,
  parameter int HICCUP_ON_CYC = 6000,
  parameter int HICCUP_OFF_CYC = 7500
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cycTick,
  input  logic [NCH-1:0] chanSel,
  input  logic [NCH-1:0] belowLo,
  input  logic [NCH-1:0] aboveHi,
  input  pgs_strobe_t    stb,
  output logic           allGood,
  output logic           anyFault,
  output logic           rstExpired,
  output logic           hicAtOn,
  output logic           hicAtOff
);
  localparam int DGW  = (DEGLITCH_CYC > 1) ? $clog2(DEGLITCH_CYC) : 1;
  localparam int RW   = $clog2(RESET_CYC + 1);
  localparam int HMAX = (HICCUP_ON_CYC > HICCUP_OFF_CYC) ? HICCUP_ON_CYC : HICCUP_OFF_CYC;
  localparam int HW   = $clog2(HMAX + 1);

  logic [NCH-1:0] goodVec;
  logic [NCH-1:0] faultVec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [DGW-1:0] dgCnt;
    logic           good;
    logic           fault;
    logic           want;
    // a judged-good channel watches for low, otherwise for high
    assign want = good ? belowLo[g] : aboveHi[g];

    always_ff @(posedge clk) begin
      if (!rstN || stb.filtClr) begin
        dgCnt <= '0;
        good  <= 1'b0;
        fault <= 1'b0;
      end else if (!want) begin
        dgCnt <= '0;
      end else if (cycTick) begin
        if (dgCnt == DGW'(DEGLITCH_CYC - 1)) begin
          dgCnt <= '0;
          good  <= ~good;
          fault <= good;   // set on good->low, cleared on low->good
        end else begin
          dgCnt <= dgCnt + 1'b1;
        end
      end
    end
    assign goodVec[g]  = good;
    assign faultVec[g] = fault;
  end

  assign allGood  = &(goodVec | ~chanSel);
  assign anyFault = |(faultVec & chanSel);

  // reset timer
  logic [RW-1:0] rstCnt;
  assign rstExpired = (rstCnt == RW'(RESET_CYC));
  always_ff @(posedge clk) begin
    if (!rstN || !stb.rstRun) rstCnt <= '0;
    else if (cycTick && !rstExpired) rstCnt <= rstCnt + 1'b1;
  end

  // shared hiccup on/off counter
  logic [HW-1:0] hicCnt;
  assign hicAtOn  = (hicCnt == HW'(HICCUP_ON_CYC - 1));
  assign hicAtOff = (hicCnt == HW'(HICCUP_OFF_CYC - 1));
  always_ff @(posedge clk) begin
    if (!rstN || stb.hicClr) hicCnt <= '0;
    else if (cycTick && stb.hicCount) hicCnt <= hicCnt + 1'b1;
  end
endmodule

// File: rtl/pgs_control.sv
`timescale 1ns/1ps
module pgs_control
  import pgs_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cycTick,
  input  logic           seqDone,
  input  logic [NCH-1:0] chanSel,
  input  logic [NCH-1:0] ovFlag,
  input  logic           allGood,
  input  logic           anyFault,
  input  logic           rstExpired,
  input  logic           hicAtOn,
  input  logic           hicAtOff,
  output pgs_strobe_t    stb,
  output logic           pgood,
  output logic           restartReq,
  output logic [NCH-1:0] hsOff
);
  phase_e phase;
  logic   onHit;
  logic   offHit;
  logic [NCH-1:0] ovReg;

  assign onHit  = cycTick && hicAtOn && anyFault;
  assign offHit = cycTick && hicAtOff;

  always_comb begin
    stb.filtClr  = (phase == PH_OFF);
    stb.rstRun   = (phase == PH_RUN) && seqDone && allGood;
    stb.hicCount = (phase == PH_OFF) || anyFault;
    stb.hicClr   = (phase == PH_RUN) ? (!anyFault || onHit) : offHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_RUN;
      pgood <= 1'b0;
      ovReg <= '0;
    end else begin
      case (phase)
        PH_RUN:  if (onHit)  phase <= PH_OFF;
        PH_OFF:  if (offHit) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
      pgood <= (phase == PH_RUN) && seqDone && allGood && rstExpired;
      ovReg <= ovFlag & chanSel;
    end
  end

  assign restartReq = (phase == PH_OFF);
  assign hsOff      = ovReg | {NCH{restartReq}};
endmodule

// File: rtl/pgood_supervisor.sv
`timescale 1ns/1ps
module pgood_supervisor
  import pgs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DEGLITCH_CYC = 5500,
  parameter int RESET_CYC = 1000000,
  parameter int HICCUP_ON_CYC = 6000,
  parameter int HICCUP_OFF_CYC = 7500
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cycTick,
  input  logic [NCH-1:0] chanSel,
  input  logic           seqDone,
  input  logic [NCH-1:0] belowLo,
  input  logic [NCH-1:0] aboveHi,
  input  logic [NCH-1:0] ovFlag,
  output logic           pgood,
  output logic           restartReq,
  output logic [NCH-1:0] hsOff
);
  pgs_strobe_t stb;
  logic allGood, anyFault, rstExpired, hicAtOn, hicAtOff;

  pgs_datapath #(
    .NCH(NCH), .DEGLITCH_CYC(DEGLITCH_CYC), .RESET_CYC(RESET_CYC),
    .HICCUP_ON_CYC(HICCUP_ON_CYC), .HICCUP_OFF_CYC(HICCUP_OFF_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .chanSel(chanSel),
    .belowLo(belowLo), .aboveHi(aboveHi), .stb(stb),
    .allGood(allGood), .anyFault(anyFault), .rstExpired(rstExpired),
    .hicAtOn(hicAtOn), .hicAtOff(hicAtOff)
  );

  pgs_control #(.NCH(NCH)) u_ctl (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .seqDone(seqDone),
    .chanSel(chanSel), .ovFlag(ovFlag), .allGood(allGood),
    .anyFault(anyFault), .rstExpired(rstExpired), .hicAtOn(hicAtOn),
    .hicAtOff(hicAtOff), .stb(stb), .pgood(pgood),
    .restartReq(restartReq), .hsOff(hsOff)
  );
endmodule

// File: rtl/pgs_checker.sv
`timescale 1ns/1ps
module pgs_checker #(
  parameter int NCH = 3,
  parameter int OFF_CYC = 7500
) (
  input logic           clk,
  input logic           rstN,
  input logic           cycTick,
  input logic [NCH-1:0] chanSel,
  input logic           seqDone,
  input logic [NCH-1:0] ovFlag,
  input logic           pgood,
  input logic           restartReq,
  input logic [NCH-1:0] hsOff
);
  localparam int TW = $clog2(OFF_CYC + 2);
  logic [TW-1:0] offTicks;

  always_ff @(posedge clk) begin
    if (!rstN || !restartReq) offTicks <= '0;
    else if (cycTick) offTicks <= offTicks + 1'b1;
  end

  AST_PG_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> $past(seqDone)); // R2
  AST_PG_RISE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgood) |-> !restartReq); // R2
  AST_NO_PG_IN_HICCUP: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> !pgood); // R5
  AST_HICCUP_AFTER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restartReq) |-> $past(!pgood)); // R5
  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(offTicks) <= OFF_CYC); // R6
  AST_OV_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(ovFlag & chanSel) & ~hsOff) == '0)); // R7
endmodule

bind pgood_supervisor pgs_checker #(.NCH(NCH), .OFF_CYC(HICCUP_OFF_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .cycTick(cycTick), .chanSel(chanSel),
  .seqDone(seqDone), .ovFlag(ovFlag), .pgood(pgood),
  .restartReq(restartReq), .hsOff(hsOff)
);

// File: tb/sim_pgood_supervisor.sv
`timescale 1ns/1ps
module sim_pgood_supervisor;
  localparam int N   = 3;
  localparam int DG  = 4;
  localparam int RST = 10;
  localparam int ON  = 6;
  localparam int OFF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycTick = 1'b1;
  logic [N-1:0] chanSel = '0, belowLo = '0, aboveHi = '0, ovFlag = '0;
  logic seqDone = 1'b0;
  logic pgood, restartReq;
  logic [N-1:0] hsOff;

  int nChecks = 0;
  int nFails  = 0;
  int tickPer = 1;
  int tickPh  = 0;

  pgood_supervisor #(.NCH(N), .DEGLITCH_CYC(DG), .RESET_CYC(RST),
    .HICCUP_ON_CYC(ON), .HICCUP_OFF_CYC(OFF)) u0 (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .chanSel(chanSel),
    .seqDone(seqDone), .belowLo(belowLo), .aboveHi(aboveHi),
    .ovFlag(ovFlag), .pgood(pgood), .restartReq(restartReq), .hsOff(hsOff));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tickPer <= 1) begin
      cycTick <= 1'b1;
    end else begin
      cycTick <= (tickPh == 0);
      tickPh  <= (tickPh >= tickPer - 1) ? 0 : tickPh + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts rising edges until the chosen output reaches lvl (0 pgood, 1 restartReq)
  task automatic measure(input int which, input logic lvl, output int n);
    n = -1;
    for (int k = 1; k <= 2000; k++) begin
      @(posedge clk); #1;
      if ((which == 0 ? pgood : restartReq) == lvl) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; chanSel = '0; belowLo = '0; aboveHi = '0;
    ovFlag = '0; seqDone = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic bringUp(input logic [N-1:0] sel, output int n);
    @(negedge clk);
    chanSel = sel; aboveHi = '1; belowLo = '0; seqDone = 1'b1;
    measure(0, 1'b1, n);
  endtask

  int n;

  initial begin
    #(20 * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    doReset();
    @(posedge clk); #1;
    check("R1 pgood", int'(pgood), 0);
    check("R1 restartReq", int'(restartReq), 0);
    check("R1 hsOff", int'(hsOff), 0);

    // sweep every selection; deselected channels held low
    for (int s = 0; s < (1 << N); s++) begin
      doReset();
      @(negedge clk);
      chanSel = N'(s); aboveHi = N'(s); belowLo = ~N'(s); seqDone = 1'b1;
      measure(0, 1'b1, n);
      if (s == 0) check("R8 none selected rise", n, RST + 1);
      else        check("R2 R8 rise latency", n, DG + RST + 1);
      repeat (2 * (DG + ON)) @(posedge clk);
      #1;
      check("R8 deselected low ignored pgood", int'(pgood), 1);
      check("R8 deselected low no restart", int'(restartReq), 0);
    end

    // per-channel glitch, drop, hiccup and restart
    for (int i = 0; i < N; i++) begin
      doReset();
      bringUp('1, n);
      check("R2 bring-up", n, DG + RST + 1);
      @(negedge clk); belowLo[i] = 1'b1; aboveHi[i] = 1'b0;
      repeat (DG - 1) @(posedge clk);
      @(negedge clk); belowLo[i] = 1'b0; aboveHi[i] = 1'b1;
      repeat (2 * DG) @(posedge clk);
      #1;
      check("R3 short low ignored", int'(pgood), 1);
      @(negedge clk); belowLo[i] = 1'b1; aboveHi[i] = 1'b0;
      measure(0, 1'b0, n);
      check("R3 drop latency", n, DG + 1);
      measure(1, 1'b1, n);
      check("R5 hiccup on-time", n, ON - 1);
      check("R5 hsOff all", int'(hsOff), (1 << N) - 1);
      check("R5 pgood low", int'(pgood), 0);
      measure(1, 1'b0, n);
      check("R6 off-time", n, OFF);
      check("R6 hsOff released", int'(hsOff), 0);
      @(negedge clk); belowLo[i] = 1'b0; aboveHi[i] = 1'b1;
      measure(0, 1'b1, n);
      check("R6 full restart latency", n, DG + RST + 1);
    end

    // band between thresholds holds state
    doReset();
    bringUp('1, n);
    @(negedge clk); belowLo[0] = 1'b0; aboveHi[0] = 1'b0;
    repeat (4 * DG) @(posedge clk);
    #1;
    check("R4 band keeps good", int'(pgood), 1);
    doReset();
    @(negedge clk); chanSel = 3'b001; seqDone = 1'b1;
    repeat (DG + RST + 5) @(posedge clk);
    #1;
    check("R4 band keeps not-good", int'(pgood), 0);

    // sequencing-done loss
    doReset();
    bringUp('1, n);
    @(negedge clk); seqDone = 1'b0;
    measure(0, 1'b0, n);
    check("R2 seqDone drop", n, 1);
    @(negedge clk); seqDone = 1'b1;
    measure(0, 1'b1, n);
    check("R2 timer restarts", n, RST + 1);

    // over-voltage
    @(negedge clk); ovFlag = 3'b101;
    @(posedge clk); #1;
    check("R7 hsOff set", int'(hsOff), 5);
    repeat (5) @(posedge clk);
    #1;
    check("R7 pgood unaffected", int'(pgood), 1);
    @(negedge clk); chanSel = 3'b001;
    @(posedge clk); #1;
    check("R8 deselected ov ignored", int'(hsOff), 1);
    @(negedge clk); ovFlag = '0;
    @(posedge clk); #1;
    check("R7 hsOff cleared", int'(hsOff), 0);

    // tick scaling
    tickPer = 3;
    doReset();
    bringUp('1, n);
    check("R9 slow tick lower bound", int'(n >= 3 * (DG + RST) - 2), 1);
    check("R9 slow tick upper bound", int'(n <= 3 * (DG + RST) + 1), 1);
    tickPer = 1;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule